// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is the fixed-rate synchronous shift mode of a controller serial port. One byte is moved at a time over a single data line that can carry data in either direction. The block drives a shift clock on a second line. It runs from the oscillator clock, and one bit period lasts twelve oscillator periods. Bits travel least-significant first.

Software starts a transmission by writing a byte with a one-cycle load strobe. It starts a reception by holding the receive enable high while the receive-done flag is clear. Within each bit period the shift clock is low for ten oscillator periods and high for two. The transmitter changes its output bit two periods after each rising shift-clock edge. Each bit is therefore set up ten periods ahead of the next rising edge. The receiver captures the data line at the rising edge itself.

When the eighth bit period ends, the transmit-done or receive-done flag rises. The flag stays high until software clears it. Requests that arrive during a transfer are dropped.

Top module: `sync_shift_port`

## Requirements
- R1: After reset the shift clock is high, the data output is 1, the data line is released (output enable 0), both done flags are 0 and busy is 0.
- R2: During a transfer every bit period is 12 clock cycles long. Counting from the start edge, the shift clock is low for the first 10 cycles of each bit period and high for the last 2. It stays high while idle.
- R3: A load strobe while idle starts a transmission. Bit i of the byte (bit 0 first) is driven from cycle 12*i to cycle 12*i+11 after the start edge. It is therefore held through the high phase of the shift clock and changes only 2 cycles after a rising edge.
- R4: In receive mode the data input is sampled at each rising edge of the shift clock. The first sample becomes bit 0 of the received byte.
- R5: The transmit-done flag rises 96 cycles after the start edge, and busy falls on the same edge. The flag stays set until the transmit-clear input is pulsed.
- R6: The receive-done flag rises 96 cycles after the start edge, and the received byte appears on the same edge. The flag stays set until the receive-clear input is pulsed.
- R7: A reception starts only when receive enable is high, the receive-done flag is 0 and the port is idle. While the receive-done flag is set, receive enable has no effect.
- R8: A load strobe or receive enable during a transfer is ignored. The transfer in progress keeps its data and its timing, and no second transfer follows it.
- R9: If a load strobe and a valid receive request come in the same cycle, the transmission wins.
- R10: The data line is driven (output enable 1) only during a transmission and is released during a reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_load | input | 1 | One-cycle strobe that writes the transmit byte |
| tx_data | input | WIDTH | Byte to transmit |
| rx_enable | input | 1 | Receive enable level |
| ti_clear | input | 1 | Clears the transmit-done flag |
| ri_clear | input | 1 | Clears the receive-done flag |
| ser_din | input | 1 | Data line value seen at the pin |
| ser_clk | output | 1 | Shift clock |
| ser_dout | output | 1 | Data line output value |
| ser_oe | output | 1 | Data line output enable |
| rx_data | output | WIDTH | Last received byte |
| ti | output | 1 | Transmit-done flag |
| ri | output | 1 | Receive-done flag |
| busy | output | 1 | Transfer in progress |

## Verification
The embedded properties check on every cycle that:
- the shift clock idles high;
- the output bit does not move while the shift clock is high;
- a done flag rises only at the end of a transfer of the matching direction;
- a transfer never changes direction midway;
- a reception starts only under its enable condition.

Other behaviours can only be shown by the bench's scenarios:
- the exact 10/2 cycle split of each bit period;
- the least-significant-first order of transmitted and received bytes;
- the 96-cycle completion point;
- that a request made mid-transfer leaves no trace;
- the blocking of reception while the receive flag is set, and transmit priority.

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int WIDTH  = 8,
  parameter int PERIOD = 12,
  parameter int SETUP  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_load,
  input  logic [WIDTH-1:0] tx_data,
  input  logic             rx_enable,
  input  logic             ti_clear,
  input  logic             ri_clear,
  input  logic             ser_din,
  output logic             ser_clk,
  output logic             ser_dout,
  output logic             ser_oe,
  output logic [WIDTH-1:0] rx_data,
  output logic             ti,
  output logic             ri,
  output logic             busy
);
  localparam int PW = $clog2(PERIOD);
  localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [PW-1:0] PH_RISE  = PW'(SETUP - 1);
  localparam logic [PW-1:0] PH_LAST  = PW'(PERIOD - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(WIDTH - 1);

  logic [PW-1:0]    phase;
  logic [BW-1:0]    bitn;
  logic [WIDTH-1:0] shreg;
  logic             mode_tx;

  wire start_tx = tx_load & ~busy;
  wire start_rx = rx_enable & ~ri & ~busy & ~tx_load;
  wire rise     = busy & (phase == PH_RISE);
  wire bit_end  = busy & (phase == PH_LAST);
  wire last     = (bitn == BIT_LAST);
  wire done     = bit_end & last;

  assign ser_oe = busy & mode_tx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      mode_tx  <= 1'b0;
      phase    <= '0;
      bitn     <= '0;
      shreg    <= '0;
      rx_data  <= '0;
      ser_clk  <= 1'b1;
      ser_dout <= 1'b1;
    end else if (start_tx || start_rx) begin
      busy     <= 1'b1;
      mode_tx  <= start_tx;
      phase    <= '0;
      bitn     <= '0;
      shreg    <= start_tx ? tx_data : '0;
      ser_clk  <= 1'b0;
      ser_dout <= start_tx ? tx_data[0] : 1'b1;
    end else if (busy) begin
      phase <= bit_end ? '0 : phase + 1'b1;
      if (rise) begin
        ser_clk <= 1'b1;
        if (!mode_tx) shreg <= {ser_din, shreg[WIDTH-1:1]};
      end
      if (bit_end) begin
        if (last) begin
          busy     <= 1'b0;
          ser_dout <= 1'b1;
          if (!mode_tx) rx_data <= shreg;
        end else begin
          bitn    <= bitn + 1'b1;
          ser_clk <= 1'b0;
          if (mode_tx) begin
            shreg    <= shreg >> 1;
            ser_dout <= shreg[1];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ti <= 1'b0;
      ri <= 1'b0;
    end else begin
      ti <= (done & mode_tx)  | (ti & ~ti_clear);
      ri <= (done & ~mode_tx) | (ri & ~ri_clear);
    end
  end

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ser_clk);

  // R3
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && ser_oe && ser_clk |-> $stable(ser_dout));

  // R5
  ti_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ti) |-> !busy && $past(ser_oe));

  // R6
  ri_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ri) |-> !busy && $past(busy) && !$past(ser_oe));

  // R7
  rx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && !ser_oe |-> $past(rx_enable) && !$past(ri));

  // R8
  mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(ser_oe));
endmodule

// File: tb/sim_sync_shift_port.sv
module sim_sync_shift_port;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_load = 1'b0, rx_enable = 1'b0, ti_clear = 1'b0, ri_clear = 1'b0, ser_din = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic ser_clk, ser_dout, ser_oe, ti, ri, busy;
  logic [W-1:0] rx_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_shift_port u0 (
    .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .tx_data(tx_data),
    .rx_enable(rx_enable), .ti_clear(ti_clear), .ri_clear(ri_clear),
    .ser_din(ser_din), .ser_clk(ser_clk), .ser_dout(ser_dout),
    .ser_oe(ser_oe), .rx_data(rx_data), .ti(ti), .ri(ri), .busy(busy)
  );

  // mode bit 1 = transmit, 0 = receive
  localparam logic [8:0] VEC [8] = '{
    {1'b1, 8'hA5}, {1'b0, 8'h5A}, {1'b1, 8'h01}, {1'b0, 8'h80},
    {1'b1, 8'hFF}, {1'b0, 8'h00}, {1'b1, 8'h3C}, {1'b0, 8'hC3}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_tx(input logic [W-1:0] b, input bit inject);
    @(negedge clk);
    tx_load = 1'b1; tx_data = b;
    @(negedge clk);
    tx_load = 1'b0;
    for (int k = 0; k < 96; k++) begin
      int i = k / 12;
      int p = k % 12;
      if (p == 0 || p == 9 || p == 10 || p == 11) begin
        chk(ser_clk == (p >= 10), "R2 shift clock shape", ser_clk, p >= 10);
        chk(ser_dout == b[i], "R3 tx bit", ser_dout, b[i]);
        chk(ser_oe == 1'b1, "R10 drive during tx", ser_oe, 1);
      end
      if (inject && k == 30) begin
        tx_load = 1'b1; tx_data = ~b; rx_enable = 1'b1;
      end
      if (inject && k == 31) begin
        tx_load = 1'b0; rx_enable = 1'b0;
      end
      if (k == 95) chk(ti == 1'b0, "R5 ti not early", ti, 0);
      @(negedge clk);
    end
    chk(ti == 1'b1, "R5 ti at end", ti, 1);
    chk(busy == 1'b0, "R5 busy falls", busy, 0);
    chk(ser_clk == 1'b1, "R2 idle clock high", ser_clk, 1);
    repeat (3) @(negedge clk);
    chk(ti == 1'b1 && busy == 1'b0, "R8 no second transfer / R5 ti held", {ti, busy}, 2);
    ti_clear = 1'b1;
    @(negedge clk);
    ti_clear = 1'b0;
    chk(ti == 1'b0, "R5 ti cleared", ti, 0);
  endtask

  task automatic run_rx(input logic [W-1:0] b, input bit clear_it);
    @(negedge clk);
    rx_enable = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 96; k++) begin
      int i = k / 12;
      int p = k % 12;
      if (p == 5) ser_din = b[i];
      if (p == 0 || p == 11) begin
        chk(ser_clk == (p >= 10), "R2 shift clock shape rx", ser_clk, p >= 10);
        chk(ser_oe == 1'b0, "R10 released during rx", ser_oe, 0);
      end
      if (k == 95) chk(ri == 1'b0, "R6 ri not early", ri, 0);
      @(negedge clk);
    end
    chk(ri == 1'b1, "R6 ri at end", ri, 1);
    chk(rx_data == b, "R4 received byte", rx_data, b);
    chk(busy == 1'b0, "R6 busy falls", busy, 0);
    if (clear_it) begin
      rx_enable = 1'b0;
      ri_clear = 1'b1;
      @(negedge clk);
      ri_clear = 1'b0;
      chk(ri == 1'b0, "R6 ri cleared", ri, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ser_clk == 1'b1 && ser_dout == 1'b1, "R1 reset line state", {ser_clk, ser_dout}, 3);
    chk(ser_oe == 1'b0 && busy == 1'b0, "R1 reset idle", {ser_oe, busy}, 0);
    chk(ti == 1'b0 && ri == 1'b0, "R1 reset flags", {ti, ri}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && ser_clk == 1'b1, "R1 idle after reset", {busy, ser_clk}, 1);

    for (int v = 0; v < 8; v++) begin
      if (VEC[v][8]) run_tx(VEC[v][7:0], 1'b0);
      else           run_rx(VEC[v][7:0], 1'b1);
    end

    // R8: requests during a transmission are ignored
    run_tx(8'h96, 1'b1);

    // R7: receive blocked while ri is set
    run_rx(8'h6B, 1'b0);
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R7 rx blocked while ri set", busy, 0);
    chk(rx_data == 8'h6B, "R7 rx data unchanged", rx_data, 8'h6B);
    ri_clear = 1'b1;
    @(negedge clk);
    ri_clear = 1'b0;
    chk(ri == 1'b0 && busy == 1'b0, "R7 ri cleared, not started yet", {ri, busy}, 0);
    @(negedge clk);
    chk(busy == 1'b1 && ser_oe == 1'b0, "R7 rx starts after clear", {busy, ser_oe}, 2);
    rx_enable = 1'b0;
    repeat (100) @(negedge clk);
    chk(ri == 1'b1, "R6 second rx done", ri, 1);
    ri_clear = 1'b1;
    @(negedge clk);
    ri_clear = 1'b0;

    // R9: transmit wins over a simultaneous receive request
    @(negedge clk);
    tx_load = 1'b1; tx_data = 8'h42; rx_enable = 1'b1;
    @(negedge clk);
    tx_load = 1'b0; rx_enable = 1'b0;
    chk(busy == 1'b1 && ser_oe == 1'b1, "R9 tx priority", {busy, ser_oe}, 3);
    chk(ser_dout == 1'b0, "R9 tx bit 0", ser_dout, 0);
    repeat (96) @(negedge clk);
    chk(ti == 1'b1 && ri == 1'b0, "R9 only ti set", {ti, ri}, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule